// File: doc/BRIEF.md
# Dot Clock Divider Controller

The block derives a dot clock from a fast pixel clock through a power-of-two divider, and it also conditions a system-clock signal that passes through it. One 8-bit control register holds every setting. It is reset to zero and is reached through an indexed write/read port. The register sets the divide code, the system-clock inversion, a packed-24-bit override that puts the system clock onto the dot-clock output, a disable for each output driver, and a PLL programming enable level.

Each clock output has its own output-enable line, and the pads use these lines to tri-state. A new divide setting is held back until the current output period has ended. Because of this the dot clock never carries a shortened pulse.

Top module: `dclk_ctrl`

## Requirements
- R1: The control register lives at index 0x02. It resets to 0x00, is written when `reg_we_i` is high with `reg_idx_i`=0x02, and reads back on `reg_rdata_o` while `reg_idx_i`=0x02. Any other index reads 0, and writes to it leave the register unchanged.
- R2: Register bits [3:1] select the divide factor as 2^code for codes 0..4. Code 0 passes the pixel clock through. For codes 1..4 the output is low for N/2 pixel cycles and then high for N/2 pixel cycles, starting low after reset.
- R3: Codes 5, 6 and 7 in bits [3:1] divide by 1.
- R4: Register bit 7 set drives `dot_oe_o` low from the cycle after the write. Clear, it drives `dot_oe_o` high.
- R5: Register bit 6 set drives `sys_oe_o` low from the cycle after the write. Clear, it drives `sys_oe_o` high.
- R6: With register bit 5 set and `pack24_i` high, `dot_clk_o` equals `sys_clk_o`.
- R7: With `pack24_i` low, register bit 5 has no effect, and `dot_clk_o` carries the divided clock.
- R8: Register bit 4 set makes `sys_clk_o` the inverse of `sys_clk_i`. Clear, `sys_clk_o` equals `sys_clk_i`.
- R9: `pll_prog_en_o` follows register bit 0.
- R10: A new divide code takes effect only at the end of a full output period of the current factor. In divide-by-1 this is the next pixel cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 8 | Register index |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed index |
| pack24_i | input | 1 | Packed 24-bit pixel format active |
| sys_clk_i | input | 1 | System clock before conditioning |
| sys_clk_o | output | 1 | Conditioned system clock |
| sys_oe_o | output | 1 | System clock driver enable |
| dot_clk_o | output | 1 | Dot clock |
| dot_oe_o | output | 1 | Dot clock driver enable |
| pll_prog_en_o | output | 1 | PLL programming enable level |

## Verification
A register write lands on the first rising edge after the strobe. The enables, the inversion, the PLL level and the read data therefore change one cycle after the write. A new divide factor appears only after the current period ends, which can take up to 16 pixel cycles. The system-clock path, the override mux and divide-by-1 are combinational, so they follow their inputs within the same cycle. The bench model applies each edge's update to the values present before that edge. It compares every output a quarter period after both the rising and the falling edge, so the pass-through clock is seen at both levels.

// File: rtl/dclk_pkg.sv
package dclk_pkg;
  typedef struct packed {
    logic       dot_off;
    logic       sys_off;
    logic       p24_sys;
    logic       sys_inv;
    logic [2:0] div_code;
    logic       pll_en;
  } ctrl_t;
endpackage

// File: rtl/dclk_regs.sv
module dclk_regs
  import dclk_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter logic [IDX_W-1:0] CTRL_IDX = 'h02,
  parameter int SEL_W = 3,
  parameter int MAX_SEL = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output ctrl_t            ctrl_o,
  output logic [SEL_W-1:0] div_sel_o
);
  logic hit;
  assign hit = (idx_i == CTRL_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_o <= '0;
    else if (we_i && hit) ctrl_o <= ctrl_t'(wdata_i);
  end

  assign rdata_o = hit ? 8'(ctrl_o) : 8'h00;
  // reserved codes fall back to divide by 1
  assign div_sel_o = (32'(ctrl_o.div_code) > MAX_SEL) ? '0 : SEL_W'(ctrl_o.div_code);

  p_reserved_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit && 32'(wdata_i[3:1]) > MAX_SEL) |=> (div_sel_o == '0));
  p_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit) |=> (8'(ctrl_o) == $past(wdata_i)));
  p_ignore_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && hit) |=> $stable(ctrl_o));
endmodule

// File: rtl/dclk_divider.sv
module dclk_divider #(
  parameter int SEL_W = 3,
  parameter int MAX_SEL = 4,
  localparam int CNT_W = (MAX_SEL < 1) ? 1 : MAX_SEL
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             div_o,
  output logic             bypass_o
);
  logic [SEL_W-1:0] act_sel;
  logic [CNT_W-1:0] cnt, half_m1;
  logic             div_q, last;

  assign half_m1  = CNT_W'(((32'd1 << act_sel) >> 1) - 32'd1);
  assign last     = (cnt == half_m1);
  assign bypass_o = (act_sel == '0);
  assign div_o    = div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_sel <= '0;
      cnt     <= '0;
      div_q   <= 1'b0;
    end else if (act_sel == '0) begin
      act_sel <= sel_i;
      cnt     <= '0;
      div_q   <= 1'b0;
    end else if (last) begin
      cnt   <= '0;
      div_q <= ~div_q;
      if (div_q) act_sel <= sel_i;  // end of full period
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_hold_sel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_sel != '0 && !(last && div_q)) |=> $stable(act_sel));
  p_duty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_sel != '0 && !last) |=> $stable(div_o));
  p_low_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_sel == '0) |=> !div_o);
endmodule

// File: rtl/dclk_outmux.sv
module dclk_outmux
  import dclk_pkg::*;
(
  input  logic  clk_i,
  input  logic  sys_clk_i,
  input  logic  pack24_i,
  input  ctrl_t ctrl_i,
  input  logic  div_i,
  input  logic  bypass_i,
  output logic  sys_clk_o,
  output logic  sys_oe_o,
  output logic  dot_clk_o,
  output logic  dot_oe_o,
  output logic  pll_prog_en_o
);
  logic divided;
  assign divided       = bypass_i ? clk_i : div_i;
  assign sys_clk_o     = sys_clk_i ^ ctrl_i.sys_inv;
  assign dot_clk_o     = (pack24_i && ctrl_i.p24_sys) ? sys_clk_o : divided;
  assign sys_oe_o      = ~ctrl_i.sys_off;
  assign dot_oe_o      = ~ctrl_i.dot_off;
  assign pll_prog_en_o = ctrl_i.pll_en;

  always_comb begin
    p_override_r6: assert (!(pack24_i && ctrl_i.p24_sys) || (dot_clk_o == sys_clk_o));
    p_no_override_r7: assert (pack24_i || (dot_clk_o == divided));
  end
endmodule

// File: rtl/dclk_ctrl.sv
module dclk_ctrl
  import dclk_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter logic [IDX_W-1:0] CTRL_IDX = 'h02,
  parameter int MAX_SEL = 4,
  localparam int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [IDX_W-1:0] reg_idx_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic             pack24_i,
  input  logic             sys_clk_i,
  output logic             sys_clk_o,
  output logic             sys_oe_o,
  output logic             dot_clk_o,
  output logic             dot_oe_o,
  output logic             pll_prog_en_o
);
  ctrl_t            ctrl;
  logic [SEL_W-1:0] div_sel;
  logic             div, bypass;

  dclk_regs #(.IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX), .SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .idx_i(reg_idx_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .ctrl_o(ctrl), .div_sel_o(div_sel));

  dclk_divider #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_div (
    .clk_i, .rst_ni, .sel_i(div_sel), .div_o(div), .bypass_o(bypass));

  dclk_outmux u_mux (
    .clk_i, .sys_clk_i, .pack24_i, .ctrl_i(ctrl), .div_i(div), .bypass_i(bypass),
    .sys_clk_o, .sys_oe_o, .dot_clk_o, .dot_oe_o, .pll_prog_en_o);

  p_dot_oe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_idx_i == CTRL_IDX) |=> (dot_oe_o == !$past(reg_wdata_i[7])));
  p_sys_oe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_idx_i == CTRL_IDX) |=> (sys_oe_o == !$past(reg_wdata_i[6])));
  p_pll_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_idx_i == CTRL_IDX) |=> (pll_prog_en_o == $past(reg_wdata_i[0])));
  always_comb begin
    p_invert_r8: assert (!rst_ni || (sys_clk_o == (sys_clk_i ^ reg_rdata_o[4])) || reg_idx_i != CTRL_IDX);
  end
endmodule

// File: tb/dclk_ctrl_test.sv
module dclk_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_idx_i = 8'h02;
  logic [7:0] reg_wdata_i = 8'h00;
  logic       pack24_i = 1'b0;
  logic       sys_clk_i = 1'b0;
  logic [7:0] reg_rdata_o;
  logic       sys_clk_o, sys_oe_o, dot_clk_o, dot_oe_o, pll_prog_en_o;

  int total = 0, bad = 0;
  bit done = 0;

  // model state
  logic [7:0] m_reg = 8'h00;
  int m_n = 1, m_pos = 0;

  dclk_ctrl uut (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  function automatic int div_of(logic [7:0] r);
    int c = int'(r[3:1]);
    return (c <= 4) ? (1 << c) : 1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_reg <= 8'h00; m_n <= 1; m_pos <= 0;
    end else begin
      if (reg_we_i && reg_idx_i == 8'h02) m_reg <= reg_wdata_i;
      if (m_n == 1 || m_pos == m_n - 1) begin
        m_pos <= 0;
        m_n   <= div_of(m_reg);
      end else m_pos <= m_pos + 1;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t act=%h exp=%h", tag, $time, act, exp);
    end
  endtask

  task automatic compare(input logic phase);
    logic exp_sys, exp_dot;
    exp_sys = sys_clk_i ^ m_reg[4];
    if (pack24_i && m_reg[5]) exp_dot = exp_sys;          // R6
    else if (m_n == 1) exp_dot = phase;                    // R2 R3 pass-through
    else exp_dot = (m_pos >= m_n / 2);                     // R2 R7 R10
    chk("R1 rdata", reg_rdata_o, (reg_idx_i == 8'h02) ? m_reg : 8'h00);
    chk("R2 R3 R6 R7 R10 dot_clk", {7'd0, dot_clk_o}, {7'd0, exp_dot});
    chk("R4 dot_oe", {7'd0, dot_oe_o}, {7'd0, ~m_reg[7]});
    chk("R5 sys_oe", {7'd0, sys_oe_o}, {7'd0, ~m_reg[6]});
    chk("R8 sys_clk", {7'd0, sys_clk_o}, {7'd0, exp_sys});
    chk("R9 pll_en", {7'd0, pll_prog_en_o}, {7'd0, m_reg[0]});
  endtask

  always @(posedge clk_i) begin #5; if (rst_ni && !done) compare(1'b1); end
  always @(negedge clk_i) begin #5; if (rst_ni && !done) compare(1'b0); end

  initial forever begin
    repeat (3) @(negedge clk_i);
    sys_clk_i = ~sys_clk_i;
  end

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_idx_i = idx; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_idx_i = 8'h02;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #35;
    // R1 reset state
    chk("R1 reset rdata", reg_rdata_o, 8'h00);
    chk("R4 reset dot_oe", {7'd0, dot_oe_o}, 8'h01);
    chk("R5 reset sys_oe", {7'd0, sys_oe_o}, 8'h01);
    rst_ni = 1'b1;
    idle(4);
    // R2 each legal factor
    for (int c = 0; c <= 4; c++) begin wr(8'h02, 8'(c << 1)); idle(40); end
    // R10 change mid-period, several times
    wr(8'h02, 8'h08); idle(5);
    wr(8'h02, 8'h02); idle(3);
    wr(8'h02, 8'h06); idle(2);
    wr(8'h02, 8'h04); idle(30);
    // R3 reserved codes
    for (int c = 5; c <= 7; c++) begin wr(8'h02, 8'(c << 1)); idle(20); end
    // R1 other index ignored, read of other index is zero
    wr(8'h02, 8'h05); wr(8'h03, 8'hFF); idle(4);
    reg_idx_i = 8'h07; idle(2); reg_idx_i = 8'h02; idle(2);
    // R6 R7 override with and without packed mode
    wr(8'h02, 8'h26); idle(10);
    pack24_i = 1'b1; idle(12);
    wr(8'h02, 8'h36); idle(12);   // R8 invert with override
    pack24_i = 1'b0; idle(12);
    wr(8'h02, 8'h06); pack24_i = 1'b1; idle(12); pack24_i = 1'b0;
    // R4 R5 R9 driver disables and PLL enable
    wr(8'h02, 8'hC1); idle(6);
    wr(8'h02, 8'h80); idle(6);
    wr(8'h02, 8'h40); idle(6);
    wr(8'h02, 8'h11); idle(6);
    // async reset mid-run
    wr(8'h02, 8'h08); idle(5);
    @(negedge clk_i); rst_ni = 1'b0; #5;
    chk("R1 reset again", reg_rdata_o, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;
    idle(10);
    finish_run();
  end
endmodule